// File: doc/BRIEF.md
# Full-Descending Word Stack Unit

This block owns the stack pointer of a 16-bit processor and turns push and pop requests into accesses on a single-port, word-addressed RAM. The pointer always names the most recently filled slot. The stack grows downward, so a push moves the pointer two bytes lower before it stores. A pop reads at the pointer and then moves it two bytes higher. The pointer is a byte address whose bit 0 is always zero. The RAM port is driven with the pointer shifted right by one bit.

A push carries one 16-bit word, and a pop returns one 16-bit word together with a one-cycle valid strobe. The pointer can also be written directly, as a general register write would do. The block reports its current value at all times. While an operation is in progress, `busy` is high and new requests are dropped.

Top module: `stack_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pointer is set to the parameter `TOP_PTR` with bit 0 cleared. After reset, `busy`, `pop_valid`, `mem_we` and `mem_re` are all low.
- R2: A push is accepted at an edge where the unit is idle and `push_req` is high. In the following cycle the pointer equals the old value minus 2, `busy` and `mem_we` are high, `mem_addr` equals the new pointer shifted right by one, and `mem_wdata` holds the pushed word. The unit is idle again one cycle later.
- R3: A pop is accepted at an edge where the unit is idle, `push_req` is low and `pop_req` is high. In the next cycle, `mem_re` is high with `mem_addr` equal to the pointer shifted right by one. In the cycle after that, the read data is captured. In the following cycle, `pop_valid` is high and the pointer equals the old value plus 2.
- R4: A pop returns the word most recently pushed to the slot that the pointer names (last in, first out).
- R5: Bit 0 of `sp_out` is zero in every cycle.
- R6: `busy` is high for every cycle after an accepted push or pop, until the unit is idle again. `push_req`, `pop_req` and `ld_en` are ignored while `busy` is high. `mem_we` and `mem_re` are never high together.
- R7: When `push_req` and `pop_req` are both high at an idle edge, only the push is performed.
- R8: `ld_en` at an idle edge loads `ld_value` with bit 0 forced to zero, and the new value appears on `sp_out` in the next cycle. The load takes priority over a push or pop requested at the same edge, and it starts no memory access.
- R9: `pop_valid` is high for exactly one cycle per pop, and `pop_data` holds the word captured for that pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_req | input | 1 | Request to push `push_data` |
| push_data | input | DATA_W | Word to push |
| pop_req | input | 1 | Request to pop one word |
| pop_data | output | DATA_W | Word returned by the last pop |
| pop_valid | output | 1 | One-cycle strobe marking `pop_data` as new |
| ld_en | input | 1 | Direct pointer write |
| ld_value | input | PTR_W | Value for the direct write (bit 0 ignored) |
| sp_out | output | PTR_W | Current pointer (byte address) |
| busy | output | 1 | An operation is in progress |
| mem_addr | output | PTR_W-1 | RAM word address |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after `mem_re` |

## Verification
A pointer that is off by one step shows up at once. It puts `sp_out` wrong in the cycle after the request, and it puts `mem_addr` wrong during the write or read cycle that follows. An error in the sequence, such as a wrong order of decrement and store, or a lost busy cycle, changes `mem_we`, `mem_re` or `busy` within one or two cycles of acceptance. The reference model is compared every cycle, so this kind of error is caught on the first operation it touches. A corrupt stored word stays hidden until it is popped, and then it appears as a `pop_data` mismatch in the `pop_valid` cycle.

// File: rtl/stk_pkg.sv
// Shared types of the stack unit.
// Assumes: a single sequencer owns all state transitions.
package stk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PUSH_WR = 2'd1,
        ST_POP_RD  = 2'd2,
        ST_POP_CAP = 2'd3
    } stk_state_t;

    typedef struct packed {
        logic load;
        logic dec;
        logic inc;
    } stk_ptr_ctl_t;
endpackage

// File: rtl/stk_seq.sv
// Sequencer: accepts requests only when idle, gives load > push > pop priority,
// and walks each push or pop through its two cycles.
// Assumes: requests are level signals sampled at the clock edge.
module stk_seq
    import stk_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_req,
    input  logic         pop_req,
    input  logic         ld_en,
    output stk_ptr_ctl_t ptr_ctl,
    output logic         take_push,
    output logic         capture,
    output logic         busy,
    output logic         mem_we,
    output logic         mem_re
);
    stk_state_t state, state_nx;
    logic       idle;

    assign idle = (state == ST_IDLE);

    // Decode the accepted request and the next state.
    always_comb begin
        state_nx     = state;
        ptr_ctl      = '0;
        take_push    = 1'b0;
        capture      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (ld_en) begin
                    ptr_ctl.load = 1'b1;
                end else if (push_req) begin
                    ptr_ctl.dec = 1'b1;
                    take_push   = 1'b1;
                    state_nx    = ST_PUSH_WR;
                end else if (pop_req) begin
                    state_nx    = ST_POP_RD;
                end
            end
            ST_PUSH_WR: state_nx = ST_IDLE;
            ST_POP_RD:  state_nx = ST_POP_CAP;
            ST_POP_CAP: begin
                ptr_ctl.inc = 1'b1;
                capture     = 1'b1;
                state_nx    = ST_IDLE;
            end
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign busy   = !idle;
    assign mem_we = (state == ST_PUSH_WR);
    assign mem_re = (state == ST_POP_RD);

    AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_we && mem_re)); // R6
    AST_PUSH_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n) take_push |=> (mem_we && busy)); // R2
    AST_READ_THEN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) mem_re |=> capture); // R3
    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (ptr_ctl.load == 1'b0 && take_push == 1'b0)); // R6
endmodule

// File: rtl/stk_ptr.sv
// Pointer register: reset to the aligned top value, direct load with bit 0
// cleared, decrement or increment by one word.
// Assumes: at most one of load, dec, inc is set in a cycle.
module stk_ptr
    import stk_pkg::*;
#(
    parameter int unsigned          PTR_W   = 16,
    parameter logic [PTR_W-1:0]     TOP_PTR = 16'h0400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  stk_ptr_ctl_t ctl,
    input  logic [PTR_W-1:0] ld_value,
    output logic [PTR_W-1:0] sp
);
    localparam logic [PTR_W-1:0] STEP    = PTR_W'(2);
    localparam logic [PTR_W-1:0] ODD_BIT = PTR_W'(1);
    localparam logic [PTR_W-1:0] TOP_AL  = TOP_PTR & ~ODD_BIT;

    // Pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n)        sp <= TOP_AL;
        else if (ctl.load) sp <= ld_value & ~ODD_BIT;
        else if (ctl.dec)  sp <= sp - STEP;
        else if (ctl.inc)  sp <= sp + STEP;
    end

    AST_SP_EVEN: assert property (@(posedge clk) disable iff (!rst_n) sp[0] == 1'b0); // R5
    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n) ctl.dec |=> sp == $past(sp) - STEP); // R2
    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n) ctl.inc |=> sp == $past(sp) + STEP); // R3
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n) ctl.load |=> sp == ($past(ld_value) & ~ODD_BIT)); // R8
endmodule

// File: rtl/stk_dpath.sv
// Data path: holds the word being pushed, captures read data for a pop and
// raises a one-cycle valid strobe.
// Assumes: RAM read data is valid in the cycle after the read enable.
module stk_dpath #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid
);
    // Hold the push word for the write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         wdata <= '0;
        else if (take_push) wdata <= push_data;
    end

    // Capture popped word and pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_data  <= '0;
            pop_valid <= 1'b0;
        end else begin
            pop_valid <= capture;
            if (capture) pop_data <= mem_rdata;
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) pop_valid |=> !pop_valid); // R9
    AST_VALID_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) capture |=> (pop_valid && pop_data == $past(mem_rdata))); // R9
endmodule

// File: rtl/stack_unit.sv
// Full-descending word stack unit: the pointer addresses the last filled slot,
// a push decrements then writes, a pop reads then increments.
// Assumes: exclusive ownership of the RAM port and a one-cycle read latency.
module stack_unit
    import stk_pkg::*;
#(
    parameter int unsigned      DATA_W  = 16,
    parameter int unsigned      PTR_W   = 16,
    parameter logic [PTR_W-1:0] TOP_PTR = 16'h0400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid,
    input  logic              ld_en,
    input  logic [PTR_W-1:0]  ld_value,
    output logic [PTR_W-1:0]  sp_out,
    output logic              busy,
    output logic [PTR_W-2:0]  mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    stk_ptr_ctl_t     ptr_ctl;
    logic             take_push;
    logic             capture;
    logic [PTR_W-1:0] sp;

    stk_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .ld_en     (ld_en),
        .ptr_ctl   (ptr_ctl),
        .take_push (take_push),
        .capture   (capture),
        .busy      (busy),
        .mem_we    (mem_we),
        .mem_re    (mem_re)
    );

    stk_ptr #(.PTR_W(PTR_W), .TOP_PTR(TOP_PTR)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ptr_ctl),
        .ld_value (ld_value),
        .sp       (sp)
    );

    stk_dpath #(.DATA_W(DATA_W)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_push (take_push),
        .push_data (push_data),
        .capture   (capture),
        .mem_rdata (mem_rdata),
        .wdata     (mem_wdata),
        .pop_data  (pop_data),
        .pop_valid (pop_valid)
    );

    assign sp_out   = sp;
    assign mem_addr = sp[PTR_W-1:1];

    AST_WRITE_AT_NEW_SP: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> $past(sp) == sp + PTR_W'(2)); // R2
    AST_NO_MEM_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n) ptr_ctl.load |=> !(mem_we || mem_re)); // R8
endmodule

// File: tb/tb_stack_unit.sv
`timescale 1ns/1ps
module tb_stack_unit;
    localparam int DW = 16;
    localparam int PW = 16;
    localparam logic [15:0] TOP = 16'h0400;

    logic clk = 0;
    logic rst_n = 0;
    logic push_req = 0, pop_req = 0, ld_en = 0;
    logic [DW-1:0] push_data = '0;
    logic [PW-1:0] ld_value = '0;
    logic [DW-1:0] pop_data, mem_wdata, mem_rdata;
    logic pop_valid, busy, mem_we, mem_re;
    logic [PW-1:0] sp_out;
    logic [PW-2:0] mem_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    stack_unit #(.DATA_W(DW), .PTR_W(PW), .TOP_PTR(TOP)) dut (
        .clk(clk), .rst_n(rst_n),
        .push_req(push_req), .push_data(push_data),
        .pop_req(pop_req), .pop_data(pop_data), .pop_valid(pop_valid),
        .ld_en(ld_en), .ld_value(ld_value), .sp_out(sp_out), .busy(busy),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Single-port RAM model, one-cycle read latency.
    logic [DW-1:0] ram [0:511];
    initial for (int i = 0; i < 512; i++) ram[i] = '0;
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr[8:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= ram[mem_addr[8:0]];
    end

    // Behavioural reference: phase 0 idle, 1 push write, 2 pop read, 3 pop capture.
    int unsigned m_sp;
    int m_phase;
    int unsigned m_wdata, m_pdata;
    bit m_pvalid;
    int unsigned m_mem [int];
    string m_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sp = TOP & 16'hFFFE; m_phase = 0; m_pvalid = 0; m_pdata = 0; m_wdata = 0;
            m_tag = "R1";
        end else begin
            m_pvalid = 0;
            case (m_phase)
                0: begin
                    if (ld_en) begin
                        m_sp = ld_value & 16'hFFFE; m_tag = "R8";
                    end else if (push_req) begin
                        m_sp = (m_sp - 2) & 16'hFFFF; m_wdata = push_data; m_phase = 1;
                        m_tag = pop_req ? "R7" : "R2";
                    end else if (pop_req) begin
                        m_phase = 2; m_tag = "R3";
                    end
                end
                1: begin m_mem[(m_sp >> 1) & 511] = m_wdata; m_phase = 0; end
                2: m_phase = 3;
                default: begin
                    m_pdata = m_mem.exists((m_sp >> 1) & 511) ? m_mem[(m_sp >> 1) & 511] : 0;
                    m_pvalid = 1; m_sp = (m_sp + 2) & 16'hFFFF; m_phase = 0;
                end
            endcase
        end
    end

    task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare on every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({m_tag, " sp"}, sp_out, m_sp);
            chk("R5 sp bit0", sp_out[0], 0);
            chk("R6 busy", busy, m_phase != 0);
            chk({m_tag, " we"}, mem_we, m_phase == 1);
            chk({m_tag, " re"}, mem_re, m_phase == 2);
            if (m_phase == 1 || m_phase == 2) chk({m_tag, " addr"}, mem_addr, m_sp >> 1);
            if (m_phase == 1) chk("R2 wdata", mem_wdata, m_wdata);
            chk("R9 valid", pop_valid, m_pvalid);
            if (m_pvalid) chk("R4 pop data", pop_data, m_pdata);
        end
    end

    task automatic idle_cycle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            push_req = 0; pop_req = 0; ld_en = 0;
        end
    endtask

    task automatic do_push(input logic [15:0] d);
        @(negedge clk); push_req = 1; push_data = d; pop_req = 0; ld_en = 0;
        @(negedge clk); push_req = 0;
    endtask

    task automatic do_pop();
        @(negedge clk); pop_req = 1; push_req = 0; ld_en = 0;
        @(negedge clk); pop_req = 0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 sp", sp_out, TOP & 16'hFFFE);
        chk("R1 busy", busy, 0);
        chk("R1 valid", pop_valid, 0);
        chk("R1 we/re", {mem_we, mem_re}, 0);
        rst_n = 1;
        idle_cycle(1);
        // R2 / R3 / R4: LIFO order
        do_push(16'hA1B2); idle_cycle(1);
        do_push(16'h1234); idle_cycle(1);
        do_push(16'hBEEF); idle_cycle(1);
        do_pop(); idle_cycle(3);
        do_pop(); idle_cycle(3);
        do_pop(); idle_cycle(3);
        // R6: request held through busy cycles
        @(negedge clk); push_req = 1; push_data = 16'h5555;
        repeat (5) @(negedge clk);
        push_req = 0; pop_req = 1;
        repeat (7) @(negedge clk);
        pop_req = 0; idle_cycle(3);
        // R7: simultaneous push and pop
        @(negedge clk); push_req = 1; pop_req = 1; push_data = 16'h7777;
        @(negedge clk); push_req = 0; pop_req = 0; idle_cycle(2);
        do_pop(); idle_cycle(3);
        // R8: odd load, load with push, load while busy
        @(negedge clk); ld_en = 1; ld_value = 16'h0101;
        @(negedge clk); ld_en = 0; idle_cycle(1);
        @(negedge clk); ld_en = 1; push_req = 1; ld_value = 16'h0201; push_data = 16'h9999;
        @(negedge clk); ld_en = 0; push_req = 0; idle_cycle(1);
        @(negedge clk); push_req = 1; push_data = 16'h4242;
        @(negedge clk); push_req = 0; ld_en = 1; ld_value = 16'h0080;
        @(negedge clk); ld_en = 0; idle_cycle(3);
        // Mixed traffic
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            push_req  = ($urandom % 3) == 0;
            pop_req   = ($urandom % 3) == 0;
            ld_en     = ($urandom % 40) == 0;
            push_data = 16'($urandom);
            ld_value  = 16'($urandom % 1024);
        end
        idle_cycle(5);
        // R1: reset again mid-run
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk);
        chk("R1 sp after reset", sp_out, TOP & 16'hFFFE);
        chk("R1 busy after reset", busy, 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule